// File: doc/BRIEF.md
# ADC Sample-and-Convert Timing Sequencer

This block paces single analog-to-digital conversions on the converter clock. A small set of conversion slots each hold an acquisition length and a trigger-line selector. When the trigger line chosen by a slot pulses, the sequencer closes the sample-and-hold switch for that slot's acquisition window. It then keeps the converter busy for a fixed conversion phase and reports completion with a one-cycle pulse that carries the slot number.

Only one sequence runs at a time. A trigger that arrives while a sequence is active is remembered per slot and is served as soon as the current sequence ends. When several slots wait, the lowest-numbered one goes first. The acquisition length and the trigger selector are read when a sequence is launched, so a change made mid-sequence applies to the next launch.

Top module: `adc_soc_sequencer`

## Requirements
- R1: The sample-enable output is high for exactly N+1 consecutive cycles, where N is the launched slot's 6-bit acquisition field (bits [6s+5:6s] of cfg_acq_i for slot s), once N is at least 6.
- R2: An acquisition field below 6 is treated as 6, so the window is never shorter than 7 cycles.
- R3: Convert-busy is high for exactly 13 cycles, starting in the cycle after the last sample-enable cycle, and is never high together with sample-enable.
- R4: The done pulse is high for one cycle, in the cycle after the last convert-busy cycle, and done_slot_o then holds the index of the slot that ran.
- R5: With the sequencer idle, a trigger seen at one rising edge makes sample-enable high in the following cycle.
- R6: Slot s fires when trig_i[k] is high, with k the 5-bit selector in bits [5s+4:5s] of cfg_sel_i; a pulse on a line that no slot selects starts nothing.
- R7: A trigger arriving during an active sequence is kept pending and its sequence starts in the cycle right after the done pulse.
- R8: When several slots request at once, the lowest slot index is launched first and the others stay pending.
- R9: Acquisition length is captured at launch; a change during a running sequence does not alter that sequence's window.
- R10: During reset, sample-enable, convert-busy and done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 32 | Trigger event lines, one cycle per event |
| cfg_acq_i | input | 24 | Acquisition fields, 6 bits per slot |
| cfg_sel_i | input | 20 | Trigger selectors, 5 bits per slot |
| sample_en_o | output | 1 | Sample-and-hold switch closed |
| conv_busy_o | output | 1 | Conversion phase active |
| done_o | output | 1 | One-cycle completion pulse |
| done_slot_o | output | 2 | Slot index belonging to the done pulse |

## Verification
The assertions take for granted that each trigger is a pulse of a single cycle on its line and that configuration is held stable around the launch edge, so a slot is never asked to start twice by one event. The stimulus raises each trigger for exactly one cycle at a falling edge and changes configuration only at falling edges, well clear of the sampling edge. Lines that no slot selects are pulsed separately to confirm they have no effect on the outputs.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_trig_arbiter.sv
module adc_trig_arbiter #(
  parameter int NUM_SLOTS = 4,
  parameter int SEL_W     = 5,
  localparam int NUM_TRIG = 1 << SEL_W,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_TRIG-1:0]        trig_i,
  input  logic [NUM_SLOTS*SEL_W-1:0] sel_i,
  input  logic                       launch_ok_i,
  output logic                       launch_o,
  output logic [SLOT_W-1:0]          grant_idx_o
);
  logic [NUM_SLOTS-1:0] hit, req, gnt_oh, pend_d, pend_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
    assign hit[s] = trig_i[sel_i[s*SEL_W +: SEL_W]];
  end

  assign req = pend_q | hit;

  always_comb begin
    gnt_oh      = '0;
    grant_idx_o = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (req[s]) begin
        gnt_oh      = '0;
        gnt_oh[s]   = 1'b1;
        grant_idx_o = SLOT_W'(s);
      end
    end
  end

  assign launch_o = launch_ok_i && (req != '0);

  always_comb begin
    pend_d = req;
    if (launch_o) pend_d = req & ~gnt_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assert_grant_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_oh));

  assert_pending_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |=> ((pend_q & $past(req & ~gnt_oh)) == $past(req & ~gnt_oh)));

  assert_idle_keeps_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch_ok_i && hit != '0) |=> ((pend_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer
  import adc_seq_pkg::*;
#(
  parameter int ACQ_W    = 6,
  parameter int CONV_CYC = 13,
  parameter int ACQ_MIN  = 6,
  parameter int SLOT_W   = 2,
  localparam int CONV_W  = $clog2(CONV_CYC),
  localparam int CNT_W   = (ACQ_W >= CONV_W) ? ACQ_W : CONV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [ACQ_W-1:0]  acq_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              launch_ok_o,
  output logic              sample_en_o,
  output logic              conv_busy_o,
  output logic              done_o,
  output logic [SLOT_W-1:0] done_slot_o
);
  seq_state_e        state_d, state_q;
  logic [CNT_W-1:0]  cnt_d, cnt_q;
  logic [SLOT_W-1:0] slot_d, slot_q;
  logic              cnt_zero;

  assign cnt_zero    = (cnt_q == '0);
  assign launch_ok_o = (state_q == ST_IDLE) || (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    slot_d  = slot_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        state_d = ST_IDLE;
        if (launch_i) begin
          state_d = ST_ACQ;
          cnt_d   = CNT_W'(acq_i);
          slot_d  = slot_i;
        end
      end
      ST_ACQ: begin
        if (cnt_zero) begin
          state_d = ST_CONV;
          cnt_d   = CNT_W'(CONV_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_CONV: begin
        if (cnt_zero) state_d = ST_DONE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      slot_q  <= slot_d;
    end
  end

  assign sample_en_o = (state_q == ST_ACQ);
  assign conv_busy_o = (state_q == ST_CONV);
  assign done_o      = (state_q == ST_DONE);
  assign done_slot_o = slot_q;

  // Phase-length observers for the checks below.
  logic [7:0] acq_run_q, conv_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_run_q  <= '0;
      conv_run_q <= '0;
    end else begin
      acq_run_q  <= sample_en_o ? acq_run_q + 1'b1 : '0;
      conv_run_q <= conv_busy_o ? conv_run_q + 1'b1 : '0;
    end
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_en_o && conv_busy_o));

  assert_conv_follows_acq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_en_o) |-> conv_busy_o);

  assert_conv_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_busy_o) |-> (conv_run_q == 8'(CONV_CYC)));

  assert_min_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_en_o) |-> (acq_run_q >= 8'(ACQ_MIN + 1)));

  assert_done_after_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_busy_o) |-> done_o);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_slot_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy_o || done_o) |-> $stable(done_slot_o));
endmodule

// File: rtl/adc_soc_sequencer.sv
module adc_soc_sequencer #(
  parameter int NUM_SLOTS = 4,
  parameter int ACQ_W     = 6,
  parameter int SEL_W     = 5,
  parameter int CONV_CYC  = 13,
  parameter int ACQ_MIN   = 6,
  localparam int NUM_TRIG = 1 << SEL_W,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_TRIG-1:0]        trig_i,
  input  logic [NUM_SLOTS*ACQ_W-1:0] cfg_acq_i,
  input  logic [NUM_SLOTS*SEL_W-1:0] cfg_sel_i,
  output logic                       sample_en_o,
  output logic                       conv_busy_o,
  output logic                       done_o,
  output logic [SLOT_W-1:0]          done_slot_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              launch, launch_ok;
  logic [SLOT_W-1:0] grant_idx;
  logic [ACQ_W-1:0]  acq_raw, acq_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  adc_trig_arbiter #(
    .NUM_SLOTS (NUM_SLOTS),
    .SEL_W     (SEL_W)
  ) i_arb (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .trig_i      (trig_i),
    .sel_i       (cfg_sel_i),
    .launch_ok_i (launch_ok),
    .launch_o    (launch),
    .grant_idx_o (grant_idx)
  );

  assign acq_raw = cfg_acq_i[grant_idx*ACQ_W +: ACQ_W];
  assign acq_eff = (acq_raw < ACQ_W'(ACQ_MIN)) ? ACQ_W'(ACQ_MIN) : acq_raw;

  adc_phase_timer #(
    .ACQ_W    (ACQ_W),
    .CONV_CYC (CONV_CYC),
    .ACQ_MIN  (ACQ_MIN),
    .SLOT_W   (SLOT_W)
  ) i_timer (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .launch_i    (launch),
    .acq_i       (acq_eff),
    .slot_i      (grant_idx),
    .launch_ok_o (launch_ok),
    .sample_en_o (sample_en_o),
    .conv_busy_o (conv_busy_o),
    .done_o      (done_o),
    .done_slot_o (done_slot_o)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_int_n |-> !(sample_en_o || conv_busy_o || done_o));

  assert_launch_starts_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    launch |=> sample_en_o);
endmodule

// File: tb/test_adc_soc_sequencer.sv
module test_adc_soc_sequencer;
  localparam int NS = 4;
  localparam int AW = 6;
  localparam int SW = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [31:0]       trig;
  logic [NS*AW-1:0]  cfg_acq;
  logic [NS*SW-1:0]  cfg_sel;
  logic              sample_en, conv_busy, done;
  logic [1:0]        done_slot;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  adc_soc_sequencer i_adc_soc_sequencer (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig),
    .cfg_acq_i   (cfg_acq),
    .cfg_sel_i   (cfg_sel),
    .sample_en_o (sample_en),
    .conv_busy_o (conv_busy),
    .done_o      (done),
    .done_slot_o (done_slot)
  );

  localparam int NV = 7;
  localparam logic [5:0] V_ACQ [NV] = '{6'd0, 6'd5, 6'd6, 6'd7, 6'd15, 6'd25, 6'd63};
  localparam int         V_WIN [NV] = '{7, 7, 7, 8, 16, 26, 64};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_acq(input int slot, input int val);
    cfg_acq[slot*AW +: AW] = AW'(val);
  endtask

  task automatic pulse(input int line);
    @(negedge clk);
    trig[line] = 1'b1;
    @(negedge clk);
    trig = '0;
  endtask

  // Measures one sequence; may inject a trigger and a new acq vector mid-window.
  task automatic measure(input int exp_w, input int exp_slot, input string tag,
                         input int inj_cyc, input int inj_line,
                         input int inj_slot, input int inj_val);
    int waits = 0, s = 0, b = 0;
    bit ovl = 1'b0;
    while (!sample_en && waits < 300) begin
      waits++;
      @(negedge clk);
    end
    check(waits == 0, {tag, " R5/R7 start delay"}, waits, 0);
    while (sample_en && s < 100) begin
      if (conv_busy) ovl = 1'b1;
      if (s == inj_cyc) begin
        trig[inj_line] = 1'b1;
        set_acq(inj_slot, inj_val);
      end
      s++;
      @(negedge clk);
      trig = '0;
    end
    check(s == exp_w, {tag, " R1/R2 window"}, s, exp_w);
    while (conv_busy && b < 100) begin
      if (sample_en) ovl = 1'b1;
      b++;
      @(negedge clk);
    end
    check(b == 13, {tag, " R3 conversion length"}, b, 13);
    check(!ovl, {tag, " R3 overlap"}, ovl, 0);
    check(done == 1'b1, {tag, " R4 done pulse"}, done, 1);
    check(done_slot == 2'(exp_slot), {tag, " R4 done slot"}, done_slot, exp_slot);
    @(negedge clk);
    check(done == 1'b0, {tag, " R4 done width"}, done, 0);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    trig    = '0;
    cfg_acq = '0;
    cfg_sel = '0;
    // selectors: slot0 line1, slot1 line3, slot2 line3, slot3 line4
    cfg_sel[0*SW +: SW] = 5'd1;
    cfg_sel[1*SW +: SW] = 5'd3;
    cfg_sel[2*SW +: SW] = 5'd3;
    cfg_sel[3*SW +: SW] = 5'd4;
    set_acq(1, 10);
    set_acq(2, 20);
    set_acq(3, 2);
    repeat (3) @(negedge clk);
    check(!sample_en && !conv_busy && !done, "R10 reset outputs",
          {sample_en, conv_busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!sample_en && !conv_busy && !done, "R10 after release",
          {sample_en, conv_busy, done}, 0);

    for (int i = 0; i < NV; i++) begin
      set_acq(0, int'(V_ACQ[i]));
      pulse(1);
      measure(V_WIN[i], 0, $sformatf("vec%0d R1", i), -1, 0, 0, 0);
      repeat (2) @(negedge clk);
    end

    // R6: unselected line has no effect
    pulse(7);
    for (int k = 0; k < 6; k++) begin
      check(!sample_en && !conv_busy, "R6 unselected line", sample_en, 0);
      @(negedge clk);
    end

    // R8: slots 1 and 2 share line 3; slot1 first (acq10 -> 11), then slot2 (20 -> 21)
    pulse(3);
    measure(11, 1, "R8 first", -1, 0, 0, 0);
    measure(21, 2, "R8 second", -1, 0, 0, 0);
    repeat (2) @(negedge clk);

    // R7: slot3 (acq 2 clamped -> 7) triggered mid-window of slot0 (acq 8 -> 9)
    set_acq(0, 8);
    pulse(1);
    measure(9, 0, "R7 active", 2, 4, 3, 2);
    measure(7, 3, "R7 pending", -1, 0, 0, 0);
    repeat (2) @(negedge clk);

    // R9: slot0 acq changed to 30 mid-run while re-triggered; current run keeps 11
    set_acq(0, 10);
    pulse(1);
    measure(11, 0, "R9 unchanged", 1, 1, 0, 30);
    measure(31, 0, "R9 new value", -1, 0, 0, 0);
    repeat (2) @(negedge clk);
    check(!sample_en && !conv_busy && !done, "R7 queue drained",
          {sample_en, conv_busy, done}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule